// File: doc/BRIEF.md
# Multi-Mode 16-bit Waveform Timer

This block is a 16-bit timer/counter that turns a prescaled tick into a count, two pulse-width-modulated pins and three event pulses. A 4-bit mode code controls everything about how it counts. It selects the direction sequence: single slope (up, then wrap to zero) or dual slope (up to TOP, then back down). It picks where TOP comes from: a fixed 8, 9, 10 or 16-bit limit, the capture register, or compare channel A. It also decides when newly written compare values take effect (at once, at TOP or at BOTTOM) and which turning point raises the overflow pulse.

Each of the two compare channels has a buffer register that the bus writes and an active register that the match logic uses. In the modes that update at once, a write goes to both registers. In the other modes, the active register copies the buffer at the mode's update point. This lets software change the duty cycle, and the period when channel A sets TOP, without producing a malformed period. The capture register is written directly and takes effect at once. Code 13 is reserved: the block parks there.

Top module: `wave_timer16`

## Requirements
- R1: While `rstN` is low and after its release, `count` is 0 and the three event pulses and both pins are low; the count, the direction state and all compare and capture registers reset to 0.
- R2: The counter, the direction state, the pins and the pulses change only on cycles where `tickEn` is high. With `tickEn` low, `count` keeps its value.
- R3: Code 0 counts up with TOP = 0xFFFF and wraps to 0. `ovfPulse` is high in the cycle after the tick taken at 0xFFFF. Compare writes take effect immediately.
- R4: Codes 4 (TOP = active compare A) and 12 (TOP = capture register) count up and clear to 0 on the tick taken at TOP. Their overflow pulse fires only at 0xFFFF, and compare writes take effect immediately.
- R5: Codes 5, 6 and 7 count up with TOP = 0x00FF, 0x01FF and 0x03FF and wrap to 0. The overflow pulse follows the tick taken at TOP, so pulses come every TOP+1 ticks.
- R6: Code 14 is single-slope PWM with TOP = capture register. Its overflow pulse comes every TOP+1 ticks.
- R7: Codes 1/2/3 (TOP 0x00FF/0x01FF/0x03FF), 8 and 10 (TOP = capture) count 0,1,…,TOP,TOP−1,…,0,1 without repeating a turning value. The overflow pulse follows the tick taken at 0 while counting down, giving 2·TOP ticks between pulses.
- R8: Compare values written in codes 1, 2, 3, 10 and 11 take effect on the tick taken at TOP while counting up. In codes 5–9, 14 and 15 they take effect on the tick taken at count 0. Until then the previous value stays in force.
- R9: `cmpAPulse` / `cmpBPulse` are high in the cycle after any tick taken while `count` equals the active value of that channel, in every mode except 13.
- R10: In codes 5–7, 14 and 15 each pin goes high after the tick taken at TOP and goes low after the tick taken at its match (the set wins when both coincide).
- R11: In codes 1–3 and 8–11 each pin goes low after a match tick taken while counting up and high after a match tick taken while counting down.
- R12: Codes 9, 11 and 15 use the active compare A value as TOP, so a new period begins at the same update point as a new duty cycle.
- R13: In code 13 the count holds, `pwmEn` is low and no pulse fires.
- R14: `pwmEn` is high in codes 1–3, 5–11, 14 and 15 and low in codes 0, 4, 12 and 13. While it is low both pins read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Prescaled count enable |
| modeSel | input | 4 | Waveform mode code |
| cmpAWr | input | 1 | Write strobe, compare A buffer |
| cmpBWr | input | 1 | Write strobe, compare B buffer |
| capWr | input | 1 | Write strobe, capture/TOP register |
| wrData | input | 16 | Write data for all three registers |
| count | output | 16 | Current count |
| pwmA | output | 1 | Channel A waveform pin |
| pwmB | output | 1 | Channel B waveform pin |
| pwmEn | output | 1 | Pin drive enable |
| ovfPulse | output | 1 | Overflow event pulse |
| cmpAPulse | output | 1 | Channel A match pulse |
| cmpBPulse | output | 1 | Channel B match pulse |

## Verification
The properties check the rules that hold on every cycle, whatever values are loaded. Without a tick the count is frozen, and code 13 freezes it as well. Both pins are quiet whenever the drive enable is low. Every event pulse follows a tick. Fixed-limit dual-slope counting never stalls. The 0xFFFF and 0x00FF wraps land on zero together with the overflow pulse. Only the bench's mode sweeps can show the buffered update timing, the pin waveforms against the match values, and TOP being taken from compare A or the capture register. They also measure the overflow period, which should be TOP+1 or 2·TOP ticks.

// File: rtl/wt_pkg.sv
`timescale 1ns/1ps
package wt_pkg;
  localparam int NCH = 2;

  typedef enum logic [2:0] {TOP_FULL, TOP_B8, TOP_B9, TOP_B10, TOP_CAPT, TOP_CMPA} topSelE;
  typedef enum logic [1:0] {UPD_NOW, UPD_AT_TOP, UPD_AT_BOT} updE;
  typedef enum logic [1:0] {FLG_MAX, FLG_TOP, FLG_BOT} ovfAtE;
  typedef enum logic [1:0] {CNT_HOLD, CNT_UP, CNT_DOWN, CNT_CLR} cntOpE;

  typedef struct packed {
    logic   dual;
    logic   pwm;
    logic   halt;
    topSelE topSel;
    updE    upd;
    ovfAtE  ovfAt;
  } modeCfgT;

  typedef struct packed {
    logic           atTop;
    logic           atBottom;
    logic           atMax;
    logic           down;
    logic [NCH-1:0] eq;
  } dpStatT;

  typedef struct packed {
    cntOpE          cntOp;
    logic           goDown;
    logic           goUp;
    logic           immWr;
    logic           loadAct;
    logic           ovfEv;
    logic [NCH-1:0] match;
    logic [NCH-1:0] pwmSet;
    logic [NCH-1:0] pwmClr;
    topSelE         topSel;
  } ctlStrobeT;

  function automatic modeCfgT decodeMode(input logic [3:0] m);
    modeCfgT c;
    c = '{dual: 1'b0, pwm: 1'b0, halt: 1'b0, topSel: TOP_FULL, upd: UPD_NOW, ovfAt: FLG_MAX};
    case (m)
      4'd0:  ;
      4'd1:  c = '{1'b1, 1'b1, 1'b0, TOP_B8,   UPD_AT_TOP, FLG_BOT};
      4'd2:  c = '{1'b1, 1'b1, 1'b0, TOP_B9,   UPD_AT_TOP, FLG_BOT};
      4'd3:  c = '{1'b1, 1'b1, 1'b0, TOP_B10,  UPD_AT_TOP, FLG_BOT};
      4'd4:  c.topSel = TOP_CMPA;
      4'd5:  c = '{1'b0, 1'b1, 1'b0, TOP_B8,   UPD_AT_BOT, FLG_TOP};
      4'd6:  c = '{1'b0, 1'b1, 1'b0, TOP_B9,   UPD_AT_BOT, FLG_TOP};
      4'd7:  c = '{1'b0, 1'b1, 1'b0, TOP_B10,  UPD_AT_BOT, FLG_TOP};
      4'd8:  c = '{1'b1, 1'b1, 1'b0, TOP_CAPT, UPD_AT_BOT, FLG_BOT};
      4'd9:  c = '{1'b1, 1'b1, 1'b0, TOP_CMPA, UPD_AT_BOT, FLG_BOT};
      4'd10: c = '{1'b1, 1'b1, 1'b0, TOP_CAPT, UPD_AT_TOP, FLG_BOT};
      4'd11: c = '{1'b1, 1'b1, 1'b0, TOP_CMPA, UPD_AT_TOP, FLG_BOT};
      4'd12: c.topSel = TOP_CAPT;
      4'd13: c.halt = 1'b1;
      4'd14: c = '{1'b0, 1'b1, 1'b0, TOP_CAPT, UPD_AT_BOT, FLG_TOP};
      default: c = '{1'b0, 1'b1, 1'b0, TOP_CMPA, UPD_AT_BOT, FLG_TOP};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/wt_ctrl.sv
`timescale 1ns/1ps
module wt_ctrl
  import wt_pkg::*;
(
  input  logic       tickEn,
  input  logic [3:0] modeSel,
  input  dpStatT     st,
  output ctlStrobeT  ctl,
  output logic       pwmMode
);
  modeCfgT cfg;

  always_comb begin
    cfg         = decodeMode(modeSel);
    ctl         = '0;
    ctl.cntOp   = CNT_HOLD;
    ctl.topSel  = cfg.topSel;
    ctl.immWr   = (cfg.upd == UPD_NOW);
    ctl.goUp    = !cfg.dual;
    pwmMode     = cfg.pwm & !cfg.halt;

    if (tickEn && !cfg.halt) begin
      // direction sequence
      if (cfg.dual) begin
        if (!st.down) begin
          if (st.atTop) begin
            if (!st.atBottom) begin
              ctl.cntOp  = CNT_DOWN;
              ctl.goDown = 1'b1;
            end
          end else begin
            ctl.cntOp = CNT_UP;
          end
        end else if (st.atBottom) begin
          ctl.cntOp = CNT_UP;
          ctl.goUp  = 1'b1;
        end else begin
          ctl.cntOp = CNT_DOWN;
        end
      end else begin
        ctl.cntOp = st.atTop ? CNT_CLR : CNT_UP;
      end

      // buffered compare update point
      case (cfg.upd)
        UPD_AT_TOP: ctl.loadAct = st.atTop & !st.down;
        UPD_AT_BOT: ctl.loadAct = st.atBottom;
        default:    ctl.loadAct = 1'b0;
      endcase

      // overflow event point
      case (cfg.ovfAt)
        FLG_TOP: ctl.ovfEv = st.atTop;
        FLG_BOT: ctl.ovfEv = st.atBottom & st.down;
        default: ctl.ovfEv = st.atMax;
      endcase

      // per-channel match and pin actions
      for (int ch = 0; ch < NCH; ch++) begin
        ctl.match[ch] = st.eq[ch];
        if (cfg.pwm) begin
          if (cfg.dual) begin
            ctl.pwmSet[ch] = st.eq[ch] & st.down;
            ctl.pwmClr[ch] = st.eq[ch] & !st.down;
          end else begin
            ctl.pwmSet[ch] = st.atTop;
            ctl.pwmClr[ch] = st.eq[ch] & !st.atTop;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wt_datapath.sv
`timescale 1ns/1ps
module wt_datapath
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctlStrobeT      ctl,
  input  logic [NCH-1:0] cmpWr,
  input  logic           capWr,
  input  logic [W-1:0]   wrData,
  output logic [W-1:0]   count,
  output dpStatT         st,
  output logic [NCH-1:0] pwmQ,
  output logic [NCH-1:0] hitQ,
  output logic           ovfQ
);
  localparam logic [W-1:0] TOP8  = W'((32'd1 << 8)  - 32'd1);
  localparam logic [W-1:0] TOP9  = W'((32'd1 << 9)  - 32'd1);
  localparam logic [W-1:0] TOP10 = W'((32'd1 << 10) - 32'd1);
  localparam logic [W-1:0] FULL  = '1;

  logic [W-1:0]   cnt;
  logic           downR;
  logic [W-1:0]   capR;
  logic [W-1:0]   topVal;
  logic [W-1:0]   actA;
  logic [NCH-1:0] eqV;

  // counter and direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      downR <= 1'b0;
    end else begin
      case (ctl.cntOp)
        CNT_UP:   cnt <= cnt + 1'b1;
        CNT_DOWN: cnt <= cnt - 1'b1;
        CNT_CLR:  cnt <= '0;
        default:  cnt <= cnt;
      endcase
      if (ctl.goDown)    downR <= 1'b1;
      else if (ctl.goUp) downR <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      capR <= '0;
    else if (capWr) capR <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfQ <= 1'b0;
    else       ovfQ <= ctl.ovfEv;
  end

  // compare channels
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [W-1:0] bufR;
    logic [W-1:0] actR;
    logic         pwmR;
    logic         hitR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufR <= '0;
        actR <= '0;
        pwmR <= 1'b0;
        hitR <= 1'b0;
      end else begin
        if (cmpWr[ch]) bufR <= wrData;
        if (cmpWr[ch] && ctl.immWr) actR <= wrData;
        else if (ctl.loadAct)       actR <= bufR;
        if (ctl.pwmSet[ch])      pwmR <= 1'b1;
        else if (ctl.pwmClr[ch]) pwmR <= 1'b0;
        hitR <= ctl.match[ch];
      end
    end

    assign eqV[ch]  = (cnt == actR);
    assign pwmQ[ch] = pwmR;
    assign hitQ[ch] = hitR;
  end

  assign actA = g_chan[0].actR;

  always_comb begin
    case (ctl.topSel)
      TOP_B8:   topVal = TOP8;
      TOP_B9:   topVal = TOP9;
      TOP_B10:  topVal = TOP10;
      TOP_CAPT: topVal = capR;
      TOP_CMPA: topVal = actA;
      default:  topVal = FULL;
    endcase
  end

  always_comb begin
    st.atTop    = (cnt == topVal);
    st.atBottom = (cnt == '0);
    st.atMax    = (cnt == FULL);
    st.down     = downR;
    st.eq       = eqV;
  end

  assign count = cnt;
endmodule

// File: rtl/wave_timer16.sv
`timescale 1ns/1ps
module wave_timer16
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic [3:0]   modeSel,
  input  logic         cmpAWr,
  input  logic         cmpBWr,
  input  logic         capWr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] count,
  output logic         pwmA,
  output logic         pwmB,
  output logic         pwmEn,
  output logic         ovfPulse,
  output logic         cmpAPulse,
  output logic         cmpBPulse
);
  ctlStrobeT      ctl;
  dpStatT         st;
  logic           pwmMode;
  logic [NCH-1:0] pwmQ;
  logic [NCH-1:0] hitQ;

  wt_ctrl ctrl_i (
    .tickEn  (tickEn),
    .modeSel (modeSel),
    .st      (st),
    .ctl     (ctl),
    .pwmMode (pwmMode)
  );

  wt_datapath #(.W(W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cmpWr  ({cmpBWr, cmpAWr}),
    .capWr  (capWr),
    .wrData (wrData),
    .count  (count),
    .st     (st),
    .pwmQ   (pwmQ),
    .hitQ   (hitQ),
    .ovfQ   (ovfPulse)
  );

  assign pwmEn     = pwmMode;
  assign pwmA      = pwmQ[0] & pwmMode;
  assign pwmB      = pwmQ[1] & pwmMode;
  assign cmpAPulse = hitQ[0];
  assign cmpBPulse = hitQ[1];
endmodule

// File: rtl/wt_checker.sv
`timescale 1ns/1ps
module wt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         tickEn,
  input logic [3:0]   modeSel,
  input logic [W-1:0] count,
  input logic         pwmA,
  input logic         pwmB,
  input logic         pwmEn,
  input logic         ovfPulse,
  input logic         cmpAPulse,
  input logic         cmpBPulse
);
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(count)); // R2

  AST_RESERVED_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 4'd13) |=> $stable(count)); // R13

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn |-> (!pwmA && !pwmB)); // R14

  AST_MAX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 4'd0 && tickEn && count == '1) |=> (count == '0 && ovfPulse)); // R3

  AST_FAST8_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 4'd5 && tickEn && count == W'(255)) |=> (count == '0 && ovfPulse)); // R5

  AST_DUAL_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && (modeSel == 4'd1 || modeSel == 4'd2 || modeSel == 4'd3)) |=> (count != $past(count))); // R7

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse || cmpAPulse || cmpBPulse) |-> $past(tickEn)); // R9
endmodule

bind wave_timer16 wt_checker #(.W(W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .modeSel   (modeSel),
  .count     (count),
  .pwmA      (pwmA),
  .pwmB      (pwmB),
  .pwmEn     (pwmEn),
  .ovfPulse  (ovfPulse),
  .cmpAPulse (cmpAPulse),
  .cmpBPulse (cmpBPulse)
);

// File: tb/wave_timer16_tb_top.sv
`timescale 1ns/1ps
module wave_timer16_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tickEn = 1'b0;
  logic [3:0]   modeSel = 4'd0;
  logic         cmpAWr = 1'b0, cmpBWr = 1'b0, capWr = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] count;
  logic         pwmA, pwmB, pwmEn, ovfPulse, cmpAPulse, cmpBPulse;

  int checks = 0;
  int errors = 0;
  bit chkOn = 1'b0;
  int cycIdx, lastOvf, gap;

  always #5 clk = ~clk;

  wave_timer16 #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeSel(modeSel),
    .cmpAWr(cmpAWr), .cmpBWr(cmpBWr), .capWr(capWr), .wrData(wrData),
    .count(count), .pwmA(pwmA), .pwmB(pwmB), .pwmEn(pwmEn),
    .ovfPulse(ovfPulse), .cmpAPulse(cmpAPulse), .cmpBPulse(cmpBPulse)
  );

  // ---- mode facts taken from the requirements ----
  function automatic bit dualOf(input logic [3:0] m);
    return m inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
  endfunction
  function automatic bit pinOf(input logic [3:0] m);
    return !(m inside {4'd0, 4'd4, 4'd12, 4'd13});
  endfunction
  function automatic int updOf(input logic [3:0] m); // 0 now, 1 at TOP, 2 at 0
    if (m inside {4'd0, 4'd4, 4'd12, 4'd13}) return 0;
    if (m inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11}) return 1;
    return 2;
  endfunction
  function automatic int ovfOf(input logic [3:0] m); // 0 max, 1 top, 2 bottom
    if (m inside {4'd0, 4'd4, 4'd12, 4'd13}) return 0;
    if (m inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15}) return 1;
    return 2;
  endfunction
  function automatic logic [W-1:0] topOf(input logic [3:0] m, input logic [W-1:0] cap, input logic [W-1:0] a);
    case (m)
      4'd1, 4'd5:  return 16'd255;
      4'd2, 4'd6:  return 16'd511;
      4'd3, 4'd7:  return 16'd1023;
      4'd4, 4'd9, 4'd11, 4'd15: return a;
      4'd8, 4'd10, 4'd12, 4'd14: return cap;
      default: return 16'hFFFF;
    endcase
  endfunction
  function automatic string reqTag(input logic [3:0] m);
    case (m)
      4'd0: return "R3";
      4'd4, 4'd12: return "R4";
      4'd5, 4'd6, 4'd7: return "R5";
      4'd14: return "R6";
      4'd9, 4'd11, 4'd15: return "R12";
      4'd13: return "R13";
      default: return "R7";
    endcase
  endfunction

  // ---- reference model ----
  logic [W-1:0] mCnt, mBufA, mBufB, mActA, mActB, mCap, mTop;
  logic         mDown, mPwmA, mPwmB, mOvf, mHitA, mHitB;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= '0; mBufA <= '0; mBufB <= '0; mActA <= '0; mActB <= '0; mCap <= '0;
      mDown <= 1'b0; mPwmA <= 1'b0; mPwmB <= 1'b0; mOvf <= 1'b0; mHitA <= 1'b0; mHitB <= 1'b0;
    end else begin
      mOvf <= 1'b0; mHitA <= 1'b0; mHitB <= 1'b0;
      if (capWr) mCap <= wrData;
      if (cmpAWr) begin mBufA <= wrData; if (updOf(modeSel) == 0) mActA <= wrData; end
      if (cmpBWr) begin mBufB <= wrData; if (updOf(modeSel) == 0) mActB <= wrData; end
      if (!dualOf(modeSel)) mDown <= 1'b0;
      if (tickEn && modeSel != 4'd13) begin
        mTop = topOf(modeSel, mCap, mActA);
        if ((updOf(modeSel) == 1 && mCnt == mTop && !mDown) || (updOf(modeSel) == 2 && mCnt == 0)) begin
          mActA <= mBufA; mActB <= mBufB;
        end
        case (ovfOf(modeSel))
          0: mOvf <= (mCnt == 16'hFFFF);
          1: mOvf <= (mCnt == mTop);
          default: mOvf <= (mCnt == 0) && mDown;
        endcase
        mHitA <= (mCnt == mActA);
        mHitB <= (mCnt == mActB);
        if (dualOf(modeSel)) begin
          if (mCnt == mActA) mPwmA <= mDown;
          if (mCnt == mActB) mPwmB <= mDown;
          if (!mDown) begin
            if (mCnt != mTop) mCnt <= mCnt + 1;
            else if (mCnt != 0) begin mCnt <= mCnt - 1; mDown <= 1'b1; end
          end else if (mCnt == 0) begin mCnt <= 1; mDown <= 1'b0; end
          else mCnt <= mCnt - 1;
        end else begin
          if (pinOf(modeSel)) begin
            if (mCnt == mTop) begin mPwmA <= 1'b1; mPwmB <= 1'b1; end
            else begin
              if (mCnt == mActA) mPwmA <= 1'b0;
              if (mCnt == mActB) mPwmB <= 1'b0;
            end
          end
          mCnt <= (mCnt == mTop) ? '0 : mCnt + 1;
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---- per-cycle comparison, away from the clock edge ----
  always @(negedge clk) begin
    if (chkOn) begin
      check(reqTag(modeSel), "count", count, mCnt);
      check(reqTag(modeSel), "ovfPulse", ovfPulse, mOvf);
      check(updOf(modeSel) == 0 ? "R9" : "R8 R9", "cmpAPulse", cmpAPulse, mHitA);
      check(updOf(modeSel) == 0 ? "R9" : "R8 R9", "cmpBPulse", cmpBPulse, mHitB);
      check(!pinOf(modeSel) ? "R14" : (dualOf(modeSel) ? "R11" : "R10"), "pwmA", pwmA, mPwmA & pinOf(modeSel));
      check(!pinOf(modeSel) ? "R14" : (dualOf(modeSel) ? "R11" : "R10"), "pwmB", pwmB, mPwmB & pinOf(modeSel));
      check("R14", "pwmEn", pwmEn, pinOf(modeSel));
      cycIdx++;
      if (ovfPulse) begin
        if (lastOvf >= 0) gap = cycIdx - lastOvf;
        lastOvf = cycIdx;
      end
    end
  end

  task automatic wrReg(input int which, input logic [W-1:0] v);
    wrData = v;
    cmpAWr = (which == 0);
    cmpBWr = (which == 1);
    capWr  = (which == 2);
    @(negedge clk);
    cmpAWr = 1'b0; cmpBWr = 1'b0; capWr = 1'b0;
  endtask

  task automatic runMode(input logic [3:0] m, input int n, input logic [W-1:0] capV,
                         input logic [W-1:0] aV, input logic [W-1:0] bV,
                         input logic [W-1:0] newA, input bit gapped, input int expGap);
    chkOn = 1'b0;
    tickEn = 1'b0;
    modeSel = m;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    wrReg(2, capV);
    wrReg(0, aV);
    wrReg(1, bV);
    lastOvf = -1; gap = 0; cycIdx = 0;
    chkOn = 1'b1;
    for (int i = 0; i < n; i++) begin
      tickEn = gapped ? (i % 4 != 3) : 1'b1;
      if (newA != 0 && i == n / 2) begin
        wrData = newA;
        cmpAWr = 1'b1;
      end
      @(negedge clk);
      cmpAWr = 1'b0;
    end
    tickEn = 1'b0;
    if (expGap != 0) check(reqTag(m), "overflow period", gap, expGap);
  endtask

  initial begin
    // R1: reset state
    modeSel = 4'd5;
    repeat (3) @(negedge clk);
    check("R1", "count in reset", count, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "count after reset", count, 0);
    check("R1", "ovfPulse after reset", ovfPulse, 0);
    check("R1", "cmpAPulse after reset", cmpAPulse, 0);
    check("R1", "pwmA after reset", pwmA, 0);

    // R2: no tick, no motion
    runMode(4'd5, 20, 16'd0, 16'd100, 16'd255, 16'd0, 1'b0, 0);
    check("R2", "count after 20 ticks", count, 20);
    repeat (6) @(negedge clk);
    check("R2", "count held without tick", count, 20);
    check("R2", "no ovf without tick", ovfPulse, 0);

    runMode(4'd0,  66000, 16'd0,  16'h1000, 16'h8000, 16'd0,  1'b0, 0);
    runMode(4'd4,  400,   16'd0,  16'd60,   16'd20,   16'd90, 1'b1, 0);
    runMode(4'd12, 400,   16'd50, 16'd10,   16'd30,   16'd0,  1'b0, 0);
    runMode(4'd1,  1100,  16'd0,  16'd100,  16'd200,  16'd150, 1'b0, 510);
    runMode(4'd2,  2200,  16'd0,  16'd300,  16'd40,   16'd0,  1'b1, 0);
    runMode(4'd3,  4200,  16'd0,  16'd1000, 16'd5,    16'd0,  1'b0, 2046);
    runMode(4'd5,  700,   16'd0,  16'd100,  16'd255,  16'd200, 1'b0, 256);
    runMode(4'd6,  1200,  16'd0,  16'd0,    16'd511,  16'd0,  1'b1, 0);
    runMode(4'd7,  2200,  16'd0,  16'd700,  16'd1,    16'd0,  1'b0, 1024);
    runMode(4'd8,  300,   16'd40, 16'd10,   16'd30,   16'd0,  1'b0, 80);
    runMode(4'd9,  500,   16'd0,  16'd30,   16'd10,   16'd50, 1'b1, 0);
    runMode(4'd10, 300,   16'd40, 16'd40,   16'd0,    16'd0,  1'b0, 80);
    runMode(4'd11, 500,   16'd0,  16'd25,   16'd12,   16'd45, 1'b0, 0);
    runMode(4'd13, 50,    16'd0,  16'd5,    16'd5,    16'd0,  1'b0, 0);
    check("R13", "reserved count", count, 0);
    check("R13", "reserved pwmEn", pwmEn, 0);
    runMode(4'd14, 300,   16'd40, 16'd20,   16'd40,   16'd0,  1'b0, 41);
    runMode(4'd15, 400,   16'd0,  16'd30,   16'd15,   16'd60, 1'b1, 0);
    runMode(4'd15, 300,   16'd0,  16'd30,   16'd15,   16'd0,  1'b0, 31);
    chkOn = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule